// File: doc/BRIEF.md
# Predicated Saturating Vector Add/Subtract Unit

This unit runs one lane-parallel saturating add or subtract over a 128-bit vector for each accepted instruction word. The vector can be split into sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit elements. The caller supplies three values beside the 32-bit instruction word: the destructive operand (`vec_a`, which also names the destination), the second operand (`vec_b`) and a predicate with one bit per byte. Every element is computed at once and clamped to the range of its result type. The result, together with a per-byte record of which elements were clamped, appears on registered outputs on the clock edge after the request.

Eight operations share the datapath. There are signed and unsigned adds, signed and unsigned subtracts, the two reversed subtracts, and two mixed-signedness accumulates. The unit checks the fixed bits of the instruction word. A word whose fixed bits do not match is flagged and leaves the result register untouched. Register files and predicate storage sit outside this block.

Top module: `sat_addsub_vu`

## Requirements
- R1: A word is accepted only if bits [31:24] are 8'h44, bits [21:19] are 3'b011 and bits [15:13] are 3'b100. Bits [12:0] are ignored. Any other valid word sets `out_illegal` for one cycle, keeps `out_valid` low and leaves `out_vec` and `out_sat` unchanged.
- R2: Bits [23:22] set the element width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64.
- R3: Operation code bits [18:16] = 0 is signed a+b, clamped to the signed range of the element.
- R4: Operation code 1 is unsigned a+b, clamped to the all-ones value.
- R5: Operation code 2 is signed a-b, clamped to the signed range. This includes 64-bit elements, where a wrapped negative result becomes the maximum and a wrapped non-negative result becomes the minimum.
- R6: Operation code 3 is unsigned a-b. It gives 0 whenever b exceeds a.
- R7: Operation code 4 adds a, read as signed, to b, read as unsigned, and clamps to the signed range.
- R8: Operation code 5 adds a, read as unsigned, to b, read as signed, and clamps to the range from 0 to the unsigned maximum.
- R9: Operation codes 6 and 7 compute b-a, signed and unsigned respectively, with the same clamping as codes 2 and 3.
- R10: The predicate bit of an element's lowest byte governs that element. An inactive element returns its `vec_a` value unchanged.
- R11: `out_sat` sets every byte bit of each active element whose result was clamped. All other bits are 0.
- R12: Results and `out_valid` appear one clock after `in_valid`. A synchronous reset clears `out_vec`, `out_sat`, `out_valid` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| vec_a | input | 128 | First operand and pass-through value |
| vec_b | input | 128 | Second operand |
| pred | input | 16 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result written this cycle |
| out_illegal | output | 1 | Rejected word seen last cycle |
| out_vec | output | 128 | Registered result vector |
| out_sat | output | 16 | Per-byte clamp record |

## Verification
Between inputs and outputs there is a single register stage, so any fault in decoding, extension or clamping reaches `out_vec` or `out_sat` on the first edge after the stimulus. The bench sees it at once. A wrong extension or range bound shows only on operands near the edges of an element's range. For that reason every width and operation code is driven with the extreme element values, and these values are replicated across all lanes. A corrupted hold path on a rejected word shows in the next cycle as a changed `out_vec` while `out_illegal` is high.

// File: rtl/sat_addsub_vu.sv
module sat_addsub_vu #(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic [VLEN-1:0]   vec_a,
  input  logic [VLEN-1:0]   vec_b,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [VLEN-1:0]   out_vec,
  output logic [VLEN/8-1:0] out_sat
);
  localparam int NB = VLEN / 8;

  logic       legal, x_sgn, y_sgn, do_add, do_rev;
  logic [1:0] size;
  logic [2:0] opc;
  logic       unused_fields;

  assign legal  = (insn[31:24] == 8'h44) && (insn[21:19] == 3'b011) && (insn[15:13] == 3'b100);
  assign size   = insn[23:22];
  assign opc    = insn[18:16];
  assign x_sgn  = ~opc[0];
  assign y_sgn  = (opc[2:1] == 2'b10) ? opc[0] : ~opc[0];
  assign do_add = ~opc[1];
  assign do_rev = opc[2] & opc[1];
  assign unused_fields = ^insn[12:0];

  logic [3:0][VLEN-1:0] res_by_sz;
  logic [3:0][NB-1:0]   sat_by_sz;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W   = 8 << s;
    localparam int BPE = W / 8;
    localparam int NL  = VLEN / W;
    localparam logic signed [W+1:0] S_HI = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] S_LO = {3'b111, {(W-1){1'b0}}};
    localparam logic signed [W+1:0] U_HI = {2'b00, {W{1'b1}}};
    localparam logic signed [W+1:0] U_LO = '0;

    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [W-1:0]          xa, yb;
      logic signed [W+1:0]   ex, ey, exact;
      logic                  act, c_hi, c_lo;

      assign xa    = vec_a[i*W +: W];
      assign yb    = vec_b[i*W +: W];
      assign ex    = x_sgn ? {{2{xa[W-1]}}, xa} : {2'b00, xa};
      assign ey    = y_sgn ? {{2{yb[W-1]}}, yb} : {2'b00, yb};
      assign exact = do_add ? (ex + ey) : (do_rev ? (ey - ex) : (ex - ey));
      assign act   = pred[i*BPE];
      assign c_hi  = x_sgn ? (exact > S_HI) : (exact > U_HI);
      assign c_lo  = x_sgn ? (exact < S_LO) : (exact < U_LO);

      assign res_by_sz[s][i*W +: W] =
          !act ? xa :
          c_hi ? (x_sgn ? S_HI[W-1:0] : U_HI[W-1:0]) :
          c_lo ? (x_sgn ? S_LO[W-1:0] : U_LO[W-1:0]) :
                 exact[W-1:0];
      assign sat_by_sz[s][i*BPE +: BPE] = {BPE{act & (c_hi | c_lo)}};

      if (s == 0) begin : g_chk
        AST_INACTIVE_KEEP: assert property (@(posedge clk) disable iff (rst)
          (in_valid && legal && size == 2'b00 && !pred[i]) |=> (out_vec[i*8 +: 8] == $past(vec_a[i*8 +: 8]))); // R10
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_vec     <= '0;
      out_sat     <= '0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      if (in_valid && legal) begin
        out_vec <= res_by_sz[size];
        out_sat <= sat_by_sz[size];
      end
    end
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> ($stable(out_vec) && $stable(out_sat))); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal)); // R12

  AST_SAT_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && size == 2'b00) |=> ((out_sat & ~$past(pred)) == '0)); // R11
endmodule

// File: tb/sat_addsub_vu_tb.sv
module sat_addsub_vu_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vec_a = '0, vec_b = '0;
  logic [15:0]  pred = '0;
  logic         out_valid, out_illegal;
  logic [127:0] out_vec;
  logic [15:0]  out_sat;

  int n_chk = 0, n_fail = 0;
  logic [127:0] exp_vec = '0;
  logic [15:0]  exp_sat = '0;
  logic         exp_valid = 1'b0, exp_ill = 1'b0;
  string        exp_tag = "R12";

  always #5 clk = ~clk;

  sat_addsub_vu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .vec_a(vec_a), .vec_b(vec_b), .pred(pred),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .out_vec(out_vec), .out_sat(out_sat)
  );

  function automatic void lane_ref(input int w, input logic [2:0] op,
                                   input logic [63:0] a_in, input logic [63:0] b_in,
                                   output logic [63:0] r, output bit s);
    logic [63:0] m, a, b;
    logic signed [71:0] x, y, e, hi, lo;
    bit xs, ys;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    a  = a_in & m;
    b  = b_in & m;
    xs = (op == 3'd0 || op == 3'd2 || op == 3'd4 || op == 3'd6);
    ys = (op == 3'd0 || op == 3'd2 || op == 3'd5 || op == 3'd6);
    x  = $signed({8'd0, a});
    y  = $signed({8'd0, b});
    if (xs && a[w-1]) x = x - (72'sd1 <<< w);
    if (ys && b[w-1]) y = y - (72'sd1 <<< w);
    case (op)
      3'd0, 3'd1, 3'd4, 3'd5: e = x + y;
      3'd2, 3'd3:             e = x - y;
      default:                e = y - x;
    endcase
    if (xs) begin
      hi = (72'sd1 <<< (w - 1)) - 72'sd1;
      lo = -(72'sd1 <<< (w - 1));
    end else begin
      hi = (72'sd1 <<< w) - 72'sd1;
      lo = 72'sd0;
    end
    s = 1'b0;
    if (e > hi) begin e = hi; s = 1'b1; end
    else if (e < lo) begin e = lo; s = 1'b1; end
    r = e[63:0] & m;
  endfunction

  function automatic void vec_ref(input logic [1:0] sz, input logic [2:0] op,
                                  input logic [127:0] a, input logic [127:0] b,
                                  input logic [15:0] p,
                                  output logic [127:0] res, output logic [15:0] sat);
    int w, bpe;
    logic [63:0] r, ea, eb, m;
    bit s;
    w   = 8 << sz;
    bpe = w / 8;
    m   = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    res = a;
    sat = '0;
    for (int i = 0; i < 128 / w; i++) begin
      ea = 64'(a >> (i * w));
      eb = 64'(b >> (i * w));
      lane_ref(w, op, ea, eb, r, s);
      if (p[i * bpe]) begin
        res = (res & ~({64'd0, m} << (i * w))) | ({64'd0, r} << (i * w));
        for (int k = 0; k < bpe; k++) sat[i * bpe + k] = s;
      end
    end
  endfunction

  function automatic logic [127:0] rep(input int w, input logic [63:0] e);
    logic [127:0] v = '0;
    for (int i = 0; i < 128 / w; i++) v = v | (128'(e & ((w == 64) ? '1 : ((64'd1 << w) - 64'd1))) << (i * w));
    return v;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] op);
    logic [31:0] t = $urandom;
    return {8'h44, sz, 3'b011, op, 3'b100, t[12:0]};
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [127:0] a,
                      input logic [127:0] b, input logic [15:0] p);
    logic [127:0] r;
    logic [15:0] s;
    bit ok;
    in_valid = v; insn = ins; vec_a = a; vec_b = b; pred = p;
    @(posedge clk);
    ok = (ins[31:24] == 8'h44) && (ins[21:19] == 3'b011) && (ins[15:13] == 3'b100);
    if (rst) begin
      exp_vec = '0; exp_sat = '0; exp_valid = 0; exp_ill = 0; exp_tag = "R12";
    end else begin
      exp_valid = v && ok;
      exp_ill   = v && !ok;
      if (v && ok) begin
        vec_ref(ins[23:22], ins[18:16], a, b, p, r, s);
        exp_vec = r; exp_sat = s;
        case (ins[18:16])
          3'd0: exp_tag = "R3 R2 R10";
          3'd1: exp_tag = "R4 R2 R10";
          3'd2: exp_tag = "R5 R2 R10";
          3'd3: exp_tag = "R6 R2 R10";
          3'd4: exp_tag = "R7 R2 R10";
          3'd5: exp_tag = "R8 R2 R10";
          default: exp_tag = "R9 R2 R10";
        endcase
      end else if (v) exp_tag = "R1";
    end
    @(negedge clk);
    n_chk++;
    if ({out_valid, out_illegal} !== {exp_valid, exp_ill}) begin
      n_fail++;
      $display("FAIL R1 R12 valid/illegal actual=%b%b expected=%b%b", out_valid, out_illegal, exp_valid, exp_ill);
    end
    n_chk++;
    if (out_vec !== exp_vec) begin
      n_fail++;
      $display("FAIL %s insn=%h result actual=%h expected=%h", exp_tag, ins, out_vec, exp_vec);
    end
    n_chk++;
    if (out_sat !== exp_sat) begin
      n_fail++;
      $display("FAIL R11 insn=%h sat actual=%h expected=%h", ins, out_sat, exp_sat);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] sp [6];
    @(negedge clk);
    step(1, mk(2'd0, 3'd0), '1, '1, '1);   // R12 reset state
    step(0, '0, '0, '0, '0);               // R12
    rst = 1'b0;
    step(0, '0, '0, '0, '0);               // R12 idle

    // R3..R9 with extreme values at every width (R2)
    for (int sz = 0; sz < 4; sz++) begin
      int w = 8 << sz;
      sp[0] = 64'd0;
      sp[1] = 64'd1;
      sp[2] = (64'd1 << (w - 1)) - 64'd1;
      sp[3] = 64'd1 << (w - 1);
      sp[4] = '1;
      sp[5] = 64'h5a3c_96e1_0f87_d24b;
      for (int op = 0; op < 8; op++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++)
            step(1, mk(2'(sz), 3'(op)), rep(w, sp[i]), rep(w, sp[j]), '1);
    end

    // R10 R11 random predicates and operands
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] t = $urandom;
      step(t[0] | t[1], mk(t[3:2], t[6:4]),
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, 16'($urandom));
    end

    // R1 rejected words after a known write
    for (int n = 0; n < 60; n++) begin
      logic [31:0] t = $urandom;
      logic [31:0] bad = mk(t[1:0], t[4:2]);
      case (t[7:6])
        2'd0: bad[31:24] = bad[31:24] ^ (8'd1 << t[10:8]);
        2'd1: bad[21:19] = bad[21:19] ^ (3'd1 << (t[9:8] % 3));
        default: bad[15:13] = bad[15:13] ^ (3'd1 << (t[9:8] % 3));
      endcase
      step(1, mk(2'd0, 3'd1), rep(8, 64'hf0), rep(8, 64'h20), '1);
      step(1, bad, {$urandom, $urandom, $urandom, $urandom}, '1, '1);
    end

    step(0, '0, '0, '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule